// File: doc/BRIEF.md
# Masked Grouped Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into a status word and presents one encoded processor priority level with a matching autovector number. A 32-bit mask word sits beside the status word. A source whose mask bit is set cannot alter its status bit. An unmasked source sets its bit when it asserts and clears its bit when it withdraws.

The request lines fall into three fixed groups. The general I/O sources (disk, keyboard and mouse, power, network frames, storage bus, timer) drive level 3. The serial controller drives level 5. The network and storage DMA channels drive level 6. Lines outside these groups still record status but raise no level. The host reads and loads either word as a whole through a one-bit select. A separate control strobe models the storage CPU-DMA mode switch. That strobe sets or clears status bit 26 directly.

Top module: `irqc_top`

## Requirements
- R1: After reset, the status word and the mask word are zero, and `ipl_o` and `vec_o` are both 0.
- R2: Status bits 0 to 13 form the level-3 group. When any of them is set and unmasked, and no higher group is pending, `ipl_o` is 3 and `vec_o` is 27.
- R3: Status bits 17 and 18 form the level-5 group. When either is set and unmasked, and level 6 is not pending, `ipl_o` is 5 and `vec_o` is 29.
- R4: Status bits 26, 27 and 28 form the level-6 group. When any of them is set and unmasked, `ipl_o` is 6 and `vec_o` is 30.
- R5: When several groups are pending, the output carries the highest pending level and that level's vector.
- R6: Suppose a source line rises while its mask bit is clear. Its status bit reads 1 after the next clock edge. If the line falls while its mask bit is clear, its status bit reads 0 after that edge.
- R7: A rise or fall on a source line whose mask bit is set leaves that status bit unchanged.
- R8: `host_rdata` shows the status word when `host_sel` is 0 and the mask word when it is 1, without delay. A clock edge with `host_we` high loads `host_wdata` into the selected word.
- R9: A clock edge with `dmamode_we` high sets status bit 26 if `dmamode_on` is 1 and clears it if `dmamode_on` is 0.
- R10: `ipl_o` and `vec_o` are 0 exactly when no status bit in any of the three groups is both set and unmasked. Setting a mask bit hides a status bit that is already set. Ungrouped bits (14-16, 19-25, 29-31) never raise a level.
- R11: When several updates hit one bit in the same clock, these precedence rules apply. An unmasked source edge overrides a host status write to that bit. The DMA-mode strobe overrides both for bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Level interrupt request lines |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 status, 1 mask |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register contents |
| dmamode_we | input | 1 | Storage CPU-DMA mode change strobe |
| dmamode_on | input | 1 | New CPU-DMA mode value |
| ipl_o | output | 3 | Encoded processor priority level |
| vec_o | output | 8 | Autovector number for that level |

## Verification
A source edge and a host status write can fall in the same clock. A DMA-mode strobe can also land in the same clock as either of them. The bench provokes these collisions in two ways. Directed steps drive a rising line, a falling line or the mode strobe together with a full-word status write. A random phase then mixes the same events freely. The results are judged per bit against the precedence in R11. For every clock, a behavioural model in the bench computes the expected status word, mask word and output level and compares them with the design.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_W   = 32;
  localparam int IPL_W   = 3;
  localparam int VEC_W   = 8;
  localparam int NUM_GRP = 3;
  localparam int DMA_BIT = 26;

  // groups listed in ascending priority; the encoder relies on this order
  localparam logic [SRC_W-1:0] GRP_BITS [NUM_GRP] =
    '{32'h0000_3FFF, 32'h0006_0000, 32'h1C00_0000};
  localparam logic [IPL_W-1:0] GRP_LVL [NUM_GRP] = '{3'd3, 3'd5, 3'd6};
  localparam logic [VEC_W-1:0] GRP_VEC [NUM_GRP] = '{8'd27, 8'd29, 8'd30};

  localparam logic [SRC_W-1:0] ALL_GRP_BITS = GRP_BITS[0] | GRP_BITS[1] | GRP_BITS[2];
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = src_i;
    rise_o = src_i & ~prev_q;
    fall_o = ~src_i & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int W    = SRC_W,
  parameter int DBIT = DMA_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic         host_we,
  input  logic         host_sel,
  input  logic [W-1:0] host_wdata,
  input  logic         dmamode_we,
  input  logic         dmamode_on,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] status_d;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic         mask_en;

  always_comb begin
    set_v    = rise_i & ~mask_q;
    clr_v    = fall_i & ~mask_q;
    mask_en  = host_we & host_sel;
    status_d = status_q;
    if (host_we && !host_sel) status_d = host_wdata;
    status_d = (status_d | set_v) & ~clr_v;
    if (dmamode_we) status_d[DBIT] = dmamode_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= host_wdata;
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic [W-1:0]     status_i,
  input  logic [W-1:0]     mask_i,
  output logic [IPL_W-1:0] ipl_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [W-1:0]       live;
  logic [NUM_GRP-1:0] hit;

  assign live = status_i & ~mask_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign hit[g] = |(live & GRP_BITS[g]);
  end

  always_comb begin
    ipl_o = '0;
    vec_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (hit[g]) begin
        ipl_o = GRP_LVL[g];
        vec_o = GRP_VEC[g];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic             host_we,
  input  logic             host_sel,
  input  logic [SRC_W-1:0] host_wdata,
  output logic [SRC_W-1:0] host_rdata,
  input  logic             dmamode_we,
  input  logic             dmamode_on,
  output logic [IPL_W-1:0] ipl_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SRC_W-1:0] rise_w;
  logic [SRC_W-1:0] fall_w;
  logic [SRC_W-1:0] status_w;
  logic [SRC_W-1:0] mask_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irqc_edge #(.W(SRC_W)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .src_i(src_i),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  irqc_regs #(.W(SRC_W), .DBIT(DMA_BIT)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .rise_i(rise_w), .fall_i(fall_w),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .dmamode_we(dmamode_we), .dmamode_on(dmamode_on),
    .status_q(status_w), .mask_q(mask_w)
  );

  irqc_prio #(.W(SRC_W)) u_prio (
    .status_i(status_w), .mask_i(mask_w), .ipl_o(ipl_o), .vec_o(vec_o)
  );

  assign host_rdata = host_sel ? mask_w : status_w;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic             dmamode_we,
  input logic             dmamode_on,
  input logic [SRC_W-1:0] rise,
  input logic [SRC_W-1:0] status,
  input logic [SRC_W-1:0] mask,
  input logic [IPL_W-1:0] ipl,
  input logic [VEC_W-1:0] vec
);
  // R6: an unmasked rise is recorded on the following edge
  assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !dmamode_we) |=> ((($past(rise) & ~$past(mask)) & ~status) == '0));

  // R7: masked bits do not move without a host or mode write
  assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !dmamode_we) |=> (((status ^ $past(status)) & $past(mask)) == '0));

  // R9: mode strobe lands in bit 26
  assert_dma_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dmamode_we |=> (status[DMA_BIT] == $past(dmamode_on)));

  // R5: a live level-6 bit always wins
  assert_top_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & ~mask & GRP_BITS[2])) |-> (ipl == 3'd6 && vec == 8'd30));

  // R3: level 5 pairs with vector 29
  assert_lvl5_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl == 3'd5) |-> (vec == 8'd29));

  // R10: quiet output when nothing grouped is live
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask & ALL_GRP_BITS) == '0) |-> (ipl == '0 && vec == '0));
endmodule

bind irqc_top irqc_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .host_we(host_we),
  .dmamode_we(dmamode_we), .dmamode_on(dmamode_on),
  .rise(rise_w), .status(status_w), .mask(mask_w),
  .ipl(ipl_o), .vec(vec_o)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        we;
  logic        sel;
  logic [31:0] wd;
  logic        dwe;
  logic        don;
  logic [31:0] rdata;
  logic [2:0]  ipl;
  logic [7:0]  vec;

  int checks = 0;
  int errors = 0;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .host_we(we), .host_sel(sel),
    .host_wdata(wd), .host_rdata(rdata), .dmamode_we(dwe), .dmamode_on(don),
    .ipl_o(ipl), .vec_o(vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_stat, m_mask, m_prev;
  int          m_cnt;
  bit          m_live;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_stat = 0; m_mask = 0; m_prev = 0; m_live = 0;
    end else if (m_cnt < 2) begin
      m_cnt++;
      m_stat = 0; m_mask = 0; m_prev = 0;
    end else begin
      logic [31:0] ns;
      ns = m_stat;
      if (we && !sel) ns = wd;
      for (int i = 0; i < 32; i++) begin
        if (!m_mask[i] && src[i] && !m_prev[i]) ns[i] = 1'b1;
        if (!m_mask[i] && !src[i] && m_prev[i]) ns[i] = 1'b0;
      end
      if (dwe) ns[26] = don;
      if (we && sel) m_mask = wd;
      m_stat = ns;
      m_prev = src;
      m_live = 1;
    end
  end

  function automatic logic [10:0] exp_out(input logic [31:0] s, input logic [31:0] m);
    logic [31:0] e;
    e = s & ~m;
    if ((e & 32'h1C00_0000) != 0) return {3'd6, 8'd30};
    if ((e & 32'h0006_0000) != 0) return {3'd5, 8'd29};
    if ((e & 32'h0000_3FFF) != 0) return {3'd3, 8'd27};
    return {3'd0, 8'd0};
  endfunction

  task automatic check_eq(input logic [31:0] act, input logic [31:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      logic [10:0] e;
      e = exp_out(m_stat, m_mask);
      check_eq({29'd0, ipl}, {29'd0, e[10:8]}, "R2/R3/R4/R5/R10 level");
      check_eq({24'd0, vec}, {24'd0, e[7:0]}, "R2/R3/R4/R5/R10 vector");
      check_eq(rdata, sel ? m_mask : m_stat, "R8 readback");
    end
  end

  // drive after posedge+2, apply on next edge, drop strobes
  task automatic step(input logic [31:0] s, input logic w, input logic sl,
                      input logic [31:0] d, input logic dw, input logic dn);
    src = s; we = w; sel = sl; wd = d; dwe = dw; don = dn;
    @(posedge clk); #2;
    we = 1'b0; dwe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    rst_n = 0; src = 0; we = 0; sel = 0; wd = 0; dwe = 0; don = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    // R1
    check_eq({21'd0, ipl, vec}, 32'd0, "R1 outputs after reset");
    check_eq(rdata, 32'd0, "R1 status after reset");
    sel = 1; #1; check_eq(rdata, 32'd0, "R1 mask after reset"); sel = 0;

    s = 32'h0000_0008;
    step(s, 0, 0, 0, 0, 0);
    check_eq({21'd0, ipl, vec}, {21'd0, 3'd3, 8'd27}, "R2 level3 group");
    check_eq(rdata, 32'h0000_0008, "R6 rise sets bit");
    s |= 32'h0002_0000; step(s, 0, 0, 0, 0, 0);
    check_eq({21'd0, ipl, vec}, {21'd0, 3'd5, 8'd29}, "R3 serial over io R5");
    s |= 32'h0800_0000; step(s, 0, 0, 0, 0, 0);
    check_eq({21'd0, ipl, vec}, {21'd0, 3'd6, 8'd30}, "R4 dma level R5");
    s &= ~32'h0800_0000; step(s, 0, 0, 0, 0, 0);
    check_eq({21'd0, ipl, vec}, {21'd0, 3'd5, 8'd29}, "R6 fall clears");
    step(s, 1, 1, 32'h0002_0000, 0, 0);
    check_eq({21'd0, ipl, vec}, {21'd0, 3'd3, 8'd27}, "R10 mask hides set bit");
    check_eq(rdata, 32'h0002_0000, "R8 mask write readback");
    s &= ~32'h0002_0000; step(s, 0, 0, 0, 0, 0);
    check_eq(rdata & 32'h0002_0000, 32'h0002_0000, "R7 masked fall ignored");
    step(s, 1, 1, 32'h0002_0020, 0, 0);
    s |= 32'h0000_0020; step(s, 0, 0, 0, 0, 0);
    check_eq(rdata & 32'h0000_0020, 32'h0, "R7 masked rise ignored");
    step(s, 1, 0, 32'h0, 0, 0);
    check_eq({21'd0, ipl, vec}, 32'd0, "R8 status write zero R10");
    s |= 32'h0010_0000; step(s, 0, 0, 0, 0, 0);
    check_eq(rdata, 32'h0010_0000, "R10 ungrouped bit recorded");
    check_eq({21'd0, ipl, vec}, 32'd0, "R10 ungrouped bit no level");
    step(s, 0, 0, 0, 1, 1);
    check_eq({21'd0, ipl, vec}, {21'd0, 3'd6, 8'd30}, "R9 mode on sets bit26");
    step(s, 0, 0, 0, 1, 0);
    check_eq(rdata & 32'h0400_0000, 32'h0, "R9 mode off clears bit26");
    // collisions
    s |= 32'h0000_0200; step(s, 1, 0, 32'h0, 1, 1);
    check_eq(rdata, 32'h0400_0200, "R11 rise and mode beat status write");
    s &= ~32'h0000_0008; step(s, 1, 0, 32'h0000_0008, 1, 0);
    check_eq(rdata, 32'h0, "R11 fall and mode beat status write");

    // mixed random phase
    for (int k = 0; k < 400; k++) begin
      logic [31:0] flip;
      flip = $urandom() & $urandom() & $urandom();
      s = s ^ flip;
      step(s, ($urandom() % 5) == 0, $urandom() % 2, $urandom() & $urandom(),
           ($urandom() % 6) == 0, $urandom() % 2);
    end
    repeat (2) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule